// File: doc/BRIEF.md
# CAN Transmit History Logger

This block keeps a short record of completed CAN transmissions. The protocol engine reports each finished transmission with a one-cycle event. The event says whether the frame came from a dedicated transmit buffer or from a shared transmit/receive FIFO, and it carries the buffer number and an 8-bit label. Events that pass the enable and the source filter go into an eight-entry history queue. Software reads the oldest record through a read port and removes it with a pop strobe.

A 16-bit control word holds the enable, the interrupt enable, the interrupt condition and the source filter. The current channel mode limits which fields a write may change, so the logging setup cannot move under live traffic. The interrupt output gives a one-cycle pulse. Depending on the condition bit, it pulses for every stored record or only when the queue has just reached six records. Status outputs report empty and full, and a sticky overflow flag records events that were lost because the queue was full.

Top module: `tx_hist_log`

## Requirements
- R1: After reset the control word reads 0x0000, `st_empty` is 1, and `st_full`, `st_ovf` and `irq` are 0. Control bits 1..7 and 11..15 always read 0, whatever value is written to them.
- R2: Control bit 0 (logging enable) takes the written value only when `chan_mode` is 2'b01 (halt) or 2'b10 (communication). In mode 2'b00 (reset) it keeps its value.
- R3: Control bit 8 (interrupt enable) takes the written value only while bit 0 is 0 before the write. Otherwise it keeps its value.
- R4: Control bits 9 (interrupt condition) and 10 (source filter) take written values only when `chan_mode` is 2'b00. In any other mode they keep their values.
- R5: While bit 0 is 0, events are not recorded and do not change any output.
- R6: With bit 10 at 0, only events with `ev_src`=0 (transmit/receive FIFO) are recorded. With bit 10 at 1, events with `ev_src`=1 (dedicated transmit buffer) are recorded as well.
- R7: The queue holds up to 8 records in arrival order. `rd_data` shows the oldest record as {src, buffer[4:0], label[7:0]}, with no clock delay. `rd_pop` removes that record, and `rd_pop` on an empty queue has no effect.
- R8: An accepted event that arrives while the queue is full is dropped. The stored records stay unchanged, `st_ovf` is set, and `st_ovf` stays at 1 until `ovf_clr` is pulsed.
- R9: With bits 8 and 9 both at 1, `irq` is high for exactly the one cycle that follows the clock edge that stores each record.
- R10: With bit 8 at 1 and bit 9 at 0, `irq` pulses for one cycle only when the number of stored records goes from 5 to 6.
- R11: A write that clears bit 0 while it is 1 empties the queue and cancels any interrupt pulse from the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_mode | input | 2 | Channel mode: 00 reset, 01 halt, 10 communication |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 16 | Control word write value |
| cfg_rdata | output | 16 | Control word read value |
| ev_valid | input | 1 | Transmission-complete event strobe |
| ev_src | input | 1 | Event origin: 0 FIFO, 1 dedicated transmit buffer |
| ev_buf | input | 5 | Originating buffer number |
| ev_label | input | 8 | Label carried with the event |
| rd_pop | input | 1 | Remove the oldest record |
| rd_data | output | 14 | Oldest record {src, buffer, label} |
| ovf_clr | input | 1 | Clear the overflow flag |
| st_empty | output | 1 | Queue holds no records |
| st_full | output | 1 | Queue holds 8 records |
| st_ovf | output | 1 | Sticky overflow flag |
| irq | output | 1 | Interrupt pulse |

## Verification
The assertions check the mode and enable write locks, and that overflow stays set, on every cycle. They also check that a full queue stays full and an empty queue stays empty when nothing drains or fills them. Further per-cycle checks cover that a dropped event or a flush never produces an interrupt, and that a pulse appears only when the interrupt enable was set. Record order and content, the mixed-source filter pattern and the single pulse at the sixth record can only be shown by the bench's scenarios. The same holds for the per-record pulses, the flush racing a new event, and the fact that a disabled logger ignores traffic.

// File: rtl/txh_pkg.sv
package txh_pkg;
  localparam int CFG_W    = 16;
  localparam int BUFN_W   = 5;
  localparam int LABEL_W  = 8;
  localparam int REC_W    = 1 + BUFN_W + LABEL_W;
  localparam int BIT_EN   = 0;
  localparam int BIT_IE   = 8;
  localparam int BIT_COND = 9;
  localparam int BIT_FILT = 10;

  localparam logic [1:0] MODE_RESET = 2'b00;
  localparam logic [1:0] MODE_HALT  = 2'b01;
  localparam logic [1:0] MODE_COMM  = 2'b10;

  typedef struct packed {
    logic               src;
    logic [BUFN_W-1:0]  bufn;
    logic [LABEL_W-1:0] label;
  } hist_rec_t;
endpackage

// File: rtl/txh_ctrl.sv
module txh_ctrl
  import txh_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] rdata,
  output logic             en,
  output logic             ie,
  output logic             cond_single,
  output logic             filt_all,
  output logic             flush
);
  logic en_q, en_d, ie_q, ie_d, cond_q, cond_d, filt_q, filt_d;
  logic run_mode;

  assign run_mode = (mode == MODE_HALT) || (mode == MODE_COMM);

  always_comb begin
    en_d   = en_q;
    ie_d   = ie_q;
    cond_d = cond_q;
    filt_d = filt_q;
    if (we && run_mode)            en_d   = wdata[BIT_EN];
    if (we && !en_q)               ie_d   = wdata[BIT_IE];
    if (we && mode == MODE_RESET) begin
      cond_d = wdata[BIT_COND];
      filt_d = wdata[BIT_FILT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      ie_q   <= 1'b0;
      cond_q <= 1'b0;
      filt_q <= 1'b0;
    end else begin
      en_q   <= en_d;
      ie_q   <= ie_d;
      cond_q <= cond_d;
      filt_q <= filt_d;
    end
  end

  always_comb begin
    rdata           = '0;
    rdata[BIT_EN]   = en_q;
    rdata[BIT_IE]   = ie_q;
    rdata[BIT_COND] = cond_q;
    rdata[BIT_FILT] = filt_q;
  end

  assign en          = en_q;
  assign ie          = ie_q;
  assign cond_single = cond_q;
  assign filt_all    = filt_q;
  assign flush       = en_q & ~en_d;

  AST_EN_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_RESET) |=> $stable(en_q)); // R2
  AST_IE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> $stable(ie_q)); // R3
  AST_FIELD_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != MODE_RESET) |=> $stable({cond_q, filt_q})); // R4
endmodule

// File: rtl/txh_fifo.sv
module txh_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 14,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic          rd,
  input  logic          flush,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_wr, do_rd;

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CW'(DEPTH));
  assign do_wr = wr & ~full & ~flush;
  assign do_rd = rd & ~empty & ~flush;

  function automatic logic [AW-1:0] step_ptr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (flush) begin
      wptr_d = '0;
      rptr_d = '0;
      cnt_d  = '0;
    end else begin
      if (do_wr) wptr_d = step_ptr(wptr_q);
      if (do_rd) rptr_d = step_ptr(rptr_q);
      if (do_wr && !do_rd)      cnt_d = cnt_q + 1'b1;
      else if (do_rd && !do_wr) cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr_q] <= wdata;
  end

  assign rdata = mem[rptr_q];
  assign count = cnt_q;

  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !rd && !flush) |=> full); // R8
  AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !wr) |=> empty); // R7
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH)); // R7
endmodule

// File: rtl/txh_irq.sv
module txh_irq #(
  parameter int CW     = 4,
  parameter int THRESH = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ie,
  input  logic          cond_single,
  input  logic          stored,
  input  logic          drained,
  input  logic          flush,
  input  logic [CW-1:0] count,
  output logic          irq
);
  logic irq_q, irq_d, hit_thresh;

  assign hit_thresh = (count == CW'(THRESH - 1)) & ~drained;

  always_comb begin
    irq_d = 1'b0;
    if (ie && stored && !flush)
      irq_d = cond_single | hit_thresh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq = irq_q;

  AST_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(ie)); // R9
  AST_FLUSH_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !irq_q); // R11
endmodule

// File: rtl/tx_hist_log.sv
module tx_hist_log
  import txh_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int THRESH = 6,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         chan_mode,
  input  logic               cfg_we,
  input  logic [CFG_W-1:0]   cfg_wdata,
  output logic [CFG_W-1:0]   cfg_rdata,
  input  logic               ev_valid,
  input  logic               ev_src,
  input  logic [BUFN_W-1:0]  ev_buf,
  input  logic [LABEL_W-1:0] ev_label,
  input  logic               rd_pop,
  output logic [REC_W-1:0]   rd_data,
  input  logic               ovf_clr,
  output logic               st_empty,
  output logic               st_full,
  output logic               st_ovf,
  output logic               irq
);
  logic en, ie, cond_single, filt_all, flush;
  logic accept, stored, drained, drop;
  logic ovf_q, ovf_d;
  logic [CW-1:0] count;
  hist_rec_t rec_in;

  txh_ctrl u_ctrl (
    .clk, .rst_n, .mode(chan_mode), .we(cfg_we), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .en, .ie, .cond_single, .filt_all, .flush
  );

  assign rec_in  = '{src: ev_src, bufn: ev_buf, label: ev_label};
  assign accept  = ev_valid & en & (~ev_src | filt_all);
  assign stored  = accept & ~st_full & ~flush;
  assign drained = rd_pop & ~st_empty & ~flush;
  assign drop    = accept & st_full & ~flush;

  txh_fifo #(.DEPTH(DEPTH), .W(REC_W)) u_fifo (
    .clk, .rst_n, .wr(accept), .rd(rd_pop), .flush,
    .wdata(rec_in), .rdata(rd_data), .empty(st_empty),
    .full(st_full), .count
  );

  txh_irq #(.CW(CW), .THRESH(THRESH)) u_irq (
    .clk, .rst_n, .ie, .cond_single, .stored, .drained, .flush,
    .count, .irq
  );

  always_comb begin
    ovf_d = ovf_q;
    if (ovf_clr) ovf_d = 1'b0;
    if (drop)    ovf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_q <= 1'b0;
    else        ovf_q <= ovf_d;
  end

  assign st_ovf = ovf_q;

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (st_ovf && !ovf_clr) |=> st_ovf); // R8
  AST_DROP_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && st_full && !rd_pop) |=> !irq); // R8
  AST_IDLE_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_valid |=> !irq); // R5
endmodule

// File: tb/sim_tx_hist_log.sv
module sim_tx_hist_log;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  chan_mode;
  logic        cfg_we;
  logic [15:0] cfg_wdata, cfg_rdata;
  logic        ev_valid, ev_src;
  logic [4:0]  ev_buf;
  logic [7:0]  ev_label;
  logic        rd_pop, ovf_clr;
  logic [13:0] rd_data;
  logic        st_empty, st_full, st_ovf, irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  tx_hist_log u0 (
    .clk, .rst_n, .chan_mode, .cfg_we, .cfg_wdata, .cfg_rdata,
    .ev_valid, .ev_src, .ev_buf, .ev_label, .rd_pop, .rd_data,
    .ovf_clr, .st_empty, .st_full, .st_ovf, .irq
  );

  // stimulus table: {src, buffer, label}; src 1 = dedicated buffer
  localparam logic [13:0] EV_TAB [8] = '{
    {1'b0, 5'd1,  8'hA1}, {1'b1, 5'd2,  8'hB2},
    {1'b0, 5'd3,  8'hC3}, {1'b0, 5'd31, 8'h00},
    {1'b1, 5'd4,  8'hD4}, {1'b0, 5'd0,  8'hFF},
    {1'b0, 5'd7,  8'h5A}, {1'b0, 5'd16, 8'h3C}
  };

  logic [13:0] mdl [8];
  int nmdl;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_cfg(input logic [1:0] m, input logic [15:0] v);
    chan_mode = m; cfg_we = 1'b1; cfg_wdata = v;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic send(input logic [13:0] e);
    ev_valid = 1'b1; {ev_src, ev_buf, ev_label} = e;
    step();
    ev_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 20000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; chan_mode = 2'b00; cfg_we = 1'b0; cfg_wdata = '0;
    ev_valid = 1'b0; ev_src = 1'b0; ev_buf = '0; ev_label = '0;
    rd_pop = 1'b0; ovf_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    // R1 reset state
    chk("R1 cfg", cfg_rdata, 16'h0000);
    chk("R1 status", {12'd0, st_empty, st_full, st_ovf, irq}, 16'h0008);

    // R1 R2 R3 R4: all-ones write in reset mode
    wr_cfg(2'b00, 16'hFFFF);
    chk("R1 R2 R4 reset-mode write", cfg_rdata, 16'h0700);
    wr_cfg(2'b00, 16'h0100);
    chk("R4 clear fields", cfg_rdata, 16'h0100);
    // R2 enable in halt, R4 fields locked
    wr_cfg(2'b01, 16'h0701);
    chk("R2 R4 halt write", cfg_rdata, 16'h0101);
    // R3 ie locked while enabled
    wr_cfg(2'b10, 16'h0001);
    chk("R3 ie lock", cfg_rdata, 16'h0101);

    // R6 R10 table walk: FIFO-only filter, threshold interrupt
    nmdl = 0;
    for (int i = 0; i < 8; i++) begin
      logic logged;
      logged = (EV_TAB[i][13] == 1'b0);
      if (logged) begin mdl[nmdl] = EV_TAB[i]; nmdl++; end
      send(EV_TAB[i]);
      chk("R10 threshold pulse", {15'd0, irq}, {15'd0, logged && nmdl == 6});
      chk("R6 filter empty", {15'd0, st_empty}, {15'd0, nmdl == 0});
    end
    step();
    chk("R10 pulse one cycle", {15'd0, irq}, 16'h0000);

    // R7 order and content
    for (int k = 0; k < 6; k++) begin
      chk("R7 head record", {2'b00, rd_data}, {2'b00, mdl[k]});
      rd_pop = 1'b1; step(); rd_pop = 1'b0;
    end
    chk("R7 drained", {14'd0, st_empty, st_full}, 16'h0002);
    rd_pop = 1'b1; step(); rd_pop = 1'b0;
    chk("R7 pop on empty", {14'd0, st_empty, st_full}, 16'h0002);

    // R4 R9: all sources, per-record interrupt
    wr_cfg(2'b00, 16'h0701);
    chk("R4 R3 R2 reset-mode reconfig", cfg_rdata, 16'h0701);
    chan_mode = 2'b10;
    for (int i = 0; i < 8; i++) begin
      send({1'b1, 5'(i), 8'(8'h10 + i)});
      chk("R9 per-record pulse", {15'd0, irq}, 16'h0001);
    end
    chk("R7 full", {15'd0, st_full}, 16'h0001);
    chk("R8 no overflow yet", {15'd0, st_ovf}, 16'h0000);
    send({1'b0, 5'd9, 8'hEE});
    chk("R8 overflow set", {15'd0, st_ovf}, 16'h0001);
    chk("R8 drop no irq", {15'd0, irq}, 16'h0000);
    chk("R8 head kept", {2'b00, rd_data}, {2'b00, 1'b1, 5'd0, 8'h10});
    step();
    chk("R8 sticky", {15'd0, st_ovf}, 16'h0001);
    ovf_clr = 1'b1; step(); ovf_clr = 1'b0;
    chk("R8 cleared", {15'd0, st_ovf}, 16'h0000);

    // R11 flush racing an event
    rd_pop = 1'b1; step(); rd_pop = 1'b0;
    ev_valid = 1'b1; {ev_src, ev_buf, ev_label} = {1'b0, 5'd5, 8'h55};
    wr_cfg(2'b10, 16'h0000);
    ev_valid = 1'b0;
    chk("R11 R4 R3 cfg after clear", cfg_rdata, 16'h0700);
    chk("R11 flushed", {14'd0, st_empty, st_full}, 16'h0002);
    chk("R11 irq dropped", {15'd0, irq}, 16'h0000);

    // R5 disabled logger
    send({1'b0, 5'd6, 8'h66});
    chk("R5 ignored empty", {15'd0, st_empty}, 16'h0001);
    chk("R5 ignored irq", {15'd0, irq}, 16'h0000);

    finish_run();
  end
endmodule